// File: doc/BRIEF.md
# Paired-Channel DMA Start/Stop and Interrupt Hub

This block is the central control logic of a multi-channel DMA controller. Transmit and receive channels alternate: even channel numbers move data toward a peripheral and odd channel numbers move data from one. A neighbouring pair of channels therefore shares one bit position in every global control and summary word. Four write strobes (TX start, TX stop, RX start, RX stop) are decoded into one-cycle start and stop pulses for the individual channel engines. The engines are outside this block and show up only as per-channel status inputs.

Each channel reports two status conditions: descriptor done and error. The block drives four interrupt outputs. Each output has its own bank of per-channel mask bits, loaded through a small write port that takes a status-shaped word. In that word, bit 0 enables descriptor done and bit 6 enables error. For every output the block registers a TX summary word and an RX summary word, one bit per channel pair. An output's interrupt line is high while either of its summary words is nonzero. Software reads a summary word to find the channel that raised the line.

Top module: `dma_pair_irq_hub`

## Requirements
- R1: A TX start strobe bit n makes `ch_start[2n]` high for exactly one cycle, in the cycle after the strobe.
- R2: An RX start strobe bit n makes `ch_start[2n+1]` high for exactly one cycle, in the cycle after the strobe.
- R3: The TX stop and RX stop strobes map bit n to `ch_stop[2n]` and `ch_stop[2n+1]` in the same way, with the same one-cycle timing.
- R4: When one channel gets a start and a stop in the same cycle, only the stop pulse is produced. Other channels in the same strobe are not affected.
- R5: Strobe bits that map to a channel number at or above NUM_CH produce no pulse at all.
- R6: After reset every mask bit is clear, and all pulses, summary words and interrupt lines are low.
- R7: A mask write to (output o, channel c) stores data bit 0 as the done enable and data bit 6 as the error enable. Data bits 1 to 5 have no effect.
- R8: The TX summary word of output o has bit n set one cycle after channel 2n shows an enabled status on output o. The RX summary word does the same for channel 2n+1.
- R9: Summary bits for channels that do not exist always read zero.
- R10: `irq[o]` is high in exactly the cycles where the TX or RX summary word of output o is nonzero, and each output is masked independently of the others.
- R11: A mask write that addresses a channel at or above NUM_CH changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start_wr | input | 32 | TX start strobe, bit n targets channel 2n |
| tx_stop_wr | input | 32 | TX stop strobe, bit n targets channel 2n |
| rx_start_wr | input | 32 | RX start strobe, bit n targets channel 2n+1 |
| rx_stop_wr | input | 32 | RX stop strobe, bit n targets channel 2n+1 |
| mask_wr | input | 1 | Mask write enable |
| mask_out | input | OUT_W | Interrupt output addressed by the mask write |
| mask_ch | input | 6 | Channel addressed by the mask write |
| mask_data | input | 7 | Mask word: bit 0 done enable, bit 6 error enable |
| ch_done | input | NUM_CH | Per-channel descriptor-done status |
| ch_err | input | NUM_CH | Per-channel error status |
| ch_start | output | NUM_CH | One-cycle start pulses |
| ch_stop | output | NUM_CH | One-cycle stop pulses |
| tx_summary | output | NUM_OUT*32 | Per-output TX summary words, output o at bits [32o+31:32o] |
| rx_summary | output | NUM_OUT*32 | Per-output RX summary words, output o at bits [32o+31:32o] |
| irq | output | NUM_OUT | Interrupt lines |

## Verification
The bench builds the hub with NUM_CH = 5, NUM_OUT = 4 and the combinational interrupt variant. An odd channel count gives three channel pairs whose last pair has only its TX half. With that build, an RX strobe to a missing channel, a mask write to a missing channel, and the zero RX summary bit for the half-empty pair can all be observed directly at the ports. Because the strobe and summary words are 32 bits wide, the bits above the third pair are also exercised as unused positions.

// File: rtl/dpih_pkg.sv
package dpih_pkg;
   localparam int MAX_CH    = 64;
   localparam int MAX_PAIRS = MAX_CH / 2;
   localparam int CH_W      = 6;
   localparam int ST_W      = 7;
   localparam int DONE_BIT  = 0;
   localparam int ERR_BIT   = 6;
endpackage

// File: rtl/dpih_cmd_decode.sv
module dpih_cmd_decode
   import dpih_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_PAIRS-1:0] tx_start,
   input  logic [MAX_PAIRS-1:0] tx_stop,
   input  logic [MAX_PAIRS-1:0] rx_start,
   input  logic [MAX_PAIRS-1:0] rx_stop,
   output logic [NUM_CH-1:0]    start_o,
   output logic [NUM_CH-1:0]    stop_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int PAIR = c / 2;
      logic go, halt;
      if (c % 2 == 0) begin : g_tx
         assign go   = tx_start[PAIR];
         assign halt = tx_stop[PAIR];
      end else begin : g_rx
         assign go   = rx_start[PAIR];
         assign halt = rx_stop[PAIR];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            start_o[c] <= 1'b0;
            stop_o[c]  <= 1'b0;
         end else begin
            start_o[c] <= go & ~halt;
            stop_o[c]  <= halt;
         end
      end
   end

   p_start_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start[0] && !tx_stop[0] |=> start_o[0]);
   p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start[0] && tx_stop[0] |=> stop_o[0] && !start_o[0]);
   p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o & stop_o) == '0);
endmodule

// File: rtl/dpih_mask_bank.sv
module dpih_mask_bank
   import dpih_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int NUM_OUT = 4,
   localparam int OUT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [OUT_W-1:0]          sel_out,
   input  logic [CH_W-1:0]           sel_ch,
   input  logic [ST_W-1:0]           wdata,
   output logic [NUM_OUT*NUM_CH-1:0] done_en,
   output logic [NUM_OUT*NUM_CH-1:0] err_en
);
   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = wr && (sel_out == OUT_W'(o)) && (sel_ch == CH_W'(c));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               done_en[o*NUM_CH+c] <= 1'b0;
               err_en[o*NUM_CH+c]  <= 1'b0;
            end else if (hit) begin
               done_en[o*NUM_CH+c] <= wdata[DONE_BIT];
               err_en[o*NUM_CH+c]  <= wdata[ERR_BIT];
            end
         end
      end
   end

   p_mask_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel_out == '0 && sel_ch == '0 |=>
         done_en[0] == $past(wdata[DONE_BIT]) && err_en[0] == $past(wdata[ERR_BIT]));
endmodule

// File: rtl/dpih_summary.sv
module dpih_summary
   import dpih_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    done_st,
   input  logic [NUM_CH-1:0]    err_st,
   input  logic [NUM_CH-1:0]    done_en,
   input  logic [NUM_CH-1:0]    err_en,
   output logic [MAX_PAIRS-1:0] tx_sum,
   output logic [MAX_PAIRS-1:0] rx_sum
);
   logic [NUM_CH-1:0] hot;
   assign hot = (done_st & done_en) | (err_st & err_en);

   for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_pair
      if (2*p < NUM_CH) begin : g_tx
         always_ff @(posedge clk) begin
            if (!rst_n) tx_sum[p] <= 1'b0;
            else        tx_sum[p] <= hot[2*p];
         end
      end else begin : g_tx_none
         assign tx_sum[p] = 1'b0;
      end
      if (2*p+1 < NUM_CH) begin : g_rx
         always_ff @(posedge clk) begin
            if (!rst_n) rx_sum[p] <= 1'b0;
            else        rx_sum[p] <= hot[2*p+1];
         end
      end else begin : g_rx_none
         assign rx_sum[p] = 1'b0;
      end
   end

   p_done_reaches_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_st[0] && done_en[0] |=> tx_sum[0]);
endmodule

// File: rtl/dma_pair_irq_hub.sv
module dma_pair_irq_hub
   import dpih_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int NUM_OUT  = 4,
   parameter bit IRQ_FLOP = 1'b0,
   localparam int OUT_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [31:0]                  tx_start_wr,
   input  logic [31:0]                  tx_stop_wr,
   input  logic [31:0]                  rx_start_wr,
   input  logic [31:0]                  rx_stop_wr,
   input  logic                         mask_wr,
   input  logic [OUT_W-1:0]             mask_out,
   input  logic [5:0]                   mask_ch,
   input  logic [6:0]                   mask_data,
   input  logic [NUM_CH-1:0]            ch_done,
   input  logic [NUM_CH-1:0]            ch_err,
   output logic [NUM_CH-1:0]            ch_start,
   output logic [NUM_CH-1:0]            ch_stop,
   output logic [NUM_OUT*MAX_PAIRS-1:0] tx_summary,
   output logic [NUM_OUT*MAX_PAIRS-1:0] rx_summary,
   output logic [NUM_OUT-1:0]           irq
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..64");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("NUM_OUT must be at least 1");
   end

   logic [NUM_OUT*NUM_CH-1:0] done_en, err_en;

   dpih_cmd_decode #(.NUM_CH(NUM_CH)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .tx_start(tx_start_wr), .tx_stop(tx_stop_wr),
      .rx_start(rx_start_wr), .rx_stop(rx_stop_wr),
      .start_o(ch_start), .stop_o(ch_stop));

   dpih_mask_bank #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(mask_wr), .sel_out(mask_out),
      .sel_ch(mask_ch), .wdata(mask_data),
      .done_en(done_en), .err_en(err_en));

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [MAX_PAIRS-1:0] tx_w, rx_w;
      dpih_summary #(.NUM_CH(NUM_CH)) u_sum (
         .clk(clk), .rst_n(rst_n),
         .done_st(ch_done), .err_st(ch_err),
         .done_en(done_en[o*NUM_CH +: NUM_CH]),
         .err_en(err_en[o*NUM_CH +: NUM_CH]),
         .tx_sum(tx_w), .rx_sum(rx_w));
      assign tx_summary[o*MAX_PAIRS +: MAX_PAIRS] = tx_w;
      assign rx_summary[o*MAX_PAIRS +: MAX_PAIRS] = rx_w;

      if (IRQ_FLOP) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq[o] <= 1'b0;
            else        irq[o] <= (|tx_w) | (|rx_w);
         end
      end else begin : g_irq_comb
         assign irq[o] = (|tx_w) | (|rx_w);
      end
   end

   p_quiet_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !IRQ_FLOP && $past(ch_done == '0 && ch_err == '0) |-> irq == '0);
endmodule

// File: tb/dma_pair_irq_hub_tb.sv
`timescale 1ns/1ps
module dma_pair_irq_hub_tb;
   localparam int NCH = 5;
   localparam int NO  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] tx_start_wr = '0, tx_stop_wr = '0, rx_start_wr = '0, rx_stop_wr = '0;
   logic mask_wr = 1'b0;
   logic [1:0] mask_out = '0;
   logic [5:0] mask_ch = '0;
   logic [6:0] mask_data = '0;
   logic [NCH-1:0] ch_done = '0, ch_err = '0;
   logic [NCH-1:0] ch_start, ch_stop;
   logic [NO*32-1:0] tx_summary, rx_summary;
   logic [NO-1:0] irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_pair_irq_hub #(.NUM_CH(NCH), .NUM_OUT(NO)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_start_wr(tx_start_wr), .tx_stop_wr(tx_stop_wr),
      .rx_start_wr(rx_start_wr), .rx_stop_wr(rx_stop_wr),
      .mask_wr(mask_wr), .mask_out(mask_out), .mask_ch(mask_ch), .mask_data(mask_data),
      .ch_done(ch_done), .ch_err(ch_err),
      .ch_start(ch_start), .ch_stop(ch_stop),
      .tx_summary(tx_summary), .rx_summary(rx_summary), .irq(irq));

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk); #1;
   endtask

   task automatic strobe(input logic [31:0] ts, tp, rs, rp);
      @(negedge clk);
      tx_start_wr = ts; tx_stop_wr = tp; rx_start_wr = rs; rx_stop_wr = rp;
      step();
      @(negedge clk);
      tx_start_wr = '0; tx_stop_wr = '0; rx_start_wr = '0; rx_stop_wr = '0;
   endtask

   task automatic wr_mask(input logic [1:0] o, input logic [5:0] c, input logic [6:0] d);
      @(negedge clk);
      mask_wr = 1'b1; mask_out = o; mask_ch = c; mask_data = d;
      @(negedge clk);
      mask_wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R6 start", 128'(ch_start), 128'd0);
      chk("R6 stop", 128'(ch_stop), 128'd0);
      chk("R6 irq", 128'(irq), 128'd0);
      chk("R6 tx summary", tx_summary, 128'd0);
      chk("R6 rx summary", rx_summary, 128'd0);
   endtask

   task automatic t_tx_start;
      strobe(32'b101, 0, 0, 0);
      chk("R1 tx start", 128'(ch_start), 128'b10001);
      chk("R1 no stop", 128'(ch_stop), 128'd0);
      step();
      chk("R1 one cycle", 128'(ch_start), 128'd0);
   endtask

   task automatic t_rx_start;
      strobe(0, 0, 32'b11, 0);
      chk("R2 rx start", 128'(ch_start), 128'b01010);
      step();
      chk("R2 one cycle", 128'(ch_start), 128'd0);
   endtask

   task automatic t_stop;
      strobe(0, 32'b010, 0, 32'b001);
      chk("R3 stop map", 128'(ch_stop), 128'b00110);
      chk("R3 no start", 128'(ch_start), 128'd0);
      step();
      chk("R3 one cycle", 128'(ch_stop), 128'd0);
   endtask

   task automatic t_stop_wins;
      strobe(32'b011, 32'b001, 0, 0);
      chk("R4 start survivor", 128'(ch_start), 128'b00100);
      chk("R4 stop wins", 128'(ch_stop), 128'b00001);
   endtask

   task automatic t_ghost_strobe;
      strobe(32'hFFFF_FFF8, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 32'hFFFF_FFFC);
      chk("R5 no start", 128'(ch_start), 128'd0);
      chk("R5 no stop", 128'(ch_stop), 128'd0);
   endtask

   task automatic t_mask_done;
      wr_mask(2'd0, 6'd0, 7'h01);
      @(negedge clk); ch_done = 5'b00001;
      step();
      chk("R8 tx bit0 out0", 128'(tx_summary[31:0]), 128'd1);
      chk("R10 irq out0 only", 128'(irq), 128'b0001);
      @(negedge clk); ch_done = '0; ch_err = 5'b00001;
      step();
      chk("R7 err not enabled", 128'(tx_summary[31:0]), 128'd0);
      chk("R10 irq drops", 128'(irq), 128'd0);
      @(negedge clk); ch_err = '0;
   endtask

   task automatic t_mask_err;
      wr_mask(2'd2, 6'd3, 7'h40);
      @(negedge clk); ch_err = 5'b01000;
      step();
      chk("R8 rx bit1 out2", 128'(rx_summary[95:64]), 128'b10);
      chk("R10 irq out2", 128'(irq), 128'b0100);
      @(negedge clk); ch_err = '0; ch_done = 5'b01000;
      step();
      chk("R7 done not enabled", 128'(irq), 128'd0);
      @(negedge clk); ch_done = '0;
   endtask

   task automatic t_other_bits;
      wr_mask(2'd3, 6'd4, 7'h3E);
      @(negedge clk); ch_done = 5'b10000; ch_err = 5'b10000;
      step();
      chk("R7 middle bits inert", 128'(tx_summary[127:96]), 128'd0);
      chk("R7 irq out3 low", 128'(irq[3]), 128'd0);
      @(negedge clk); ch_done = '0; ch_err = '0;
   endtask

   task automatic t_ghost_mask;
      wr_mask(2'd1, 6'd5, 7'h41);
      wr_mask(2'd1, 6'd63, 7'h41);
      @(negedge clk); ch_done = '1; ch_err = '1;
      step();
      chk("R11 out1 tx untouched", 128'(tx_summary[63:32]), 128'd0);
      chk("R11 out1 rx untouched", 128'(rx_summary[63:32]), 128'd0);
      chk("R11 irq1 low", 128'(irq[1]), 128'd0);
      @(negedge clk); ch_done = '0; ch_err = '0;
   endtask

   task automatic t_all_pairs;
      for (int c = 0; c < NCH; c++) wr_mask(2'd1, 6'(c), 7'h41);
      @(negedge clk); ch_err = '1;
      step();
      chk("R9 tx pairs", 128'(tx_summary[63:32]), 128'b111);
      chk("R9 rx half pair zero", 128'(rx_summary[63:32]), 128'b11);
      chk("R10 irq1 high", 128'(irq[1]), 128'd1);
      @(negedge clk); ch_err = '0;
      step();
      chk("R10 irq clears", 128'(irq), 128'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      step();
      t_reset();
      t_tx_start();
      t_rx_start();
      t_stop();
      t_stop_wins();
      t_ghost_strobe();
      t_mask_done();
      t_mask_err();
      t_other_bits();
      t_ghost_mask();
      t_all_pairs();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule